// File: doc/BRIEF.md
# Dual-Rounding Iterative Integer Divider

This block divides one integer by another over several cycles and returns a quotient and a remainder. Per operation, the caller chooses whether the operands are unsigned or two's complement, and whether the quotient rounds toward zero (truncating) or toward negative infinity (flooring).

A single radix-2 restoring core works on operand magnitudes. It retires one quotient bit per cycle. A correction stage then applies the signs and, in flooring mode, adjusts the quotient by one and the remainder by the divisor. Division by zero and the single signed overflow case each return a defined result and raise a flag.

Operations enter through a valid/ready pair. Results leave through a second valid/ready pair. Only one operation is in flight at a time. The operands are registered when the operation is accepted, so the caller may change the inputs while the division runs.

Top module: `int_divider`

## Requirements
- R1: `in_ready_o` is high only while no operation is in flight or waiting to be delivered. An operation is accepted on a rising clock edge with `in_valid_i` and `in_ready_o` both high. The operands and mode bits are registered at that edge, so later input changes do not affect the result.
- R2: `out_valid_o` rises exactly WIDTH+2 clock edges after the accepting edge. This latency is the same for every operand value, including division by zero.
- R3: While `out_valid_o` is high and `out_ready_i` is low, `out_valid_o` stays high and every result output holds its value. The edge where both are high ends the operation, and `in_ready_o` is high again after that edge.
- R4: With `floor_i`=0 and `signed_i`=1, the quotient rounds toward zero. The remainder is zero or has the sign of the dividend. The identity quotient*divisor + remainder = dividend holds.
- R5: With `floor_i`=1 and `signed_i`=1, the quotient rounds toward negative infinity. The remainder is zero or has the sign of the divisor, and the same identity holds. When the operand signs differ and the remainder is nonzero, the result differs from truncation: the quotient is one lower and the remainder is the truncated remainder plus the divisor.
- R6: Signed results, given as (truncating quotient, truncating remainder, flooring quotient, flooring remainder), are:
  - 10/3 gives (3, 1, 3, 1).
  - -10/-3 gives (3, -1, 3, -1).
  - -10/3 gives (-3, -1, -4, 2).
  - 10/-3 gives (-3, 1, -4, -2).
- R7: With `signed_i`=0, the operands are unsigned. The quotient is the integer quotient, the remainder is less than the divisor, and `floor_i` has no effect on any output.
- R8: A zero divisor sets `div_zero_o`. The quotient is then all ones and the remainder equals the dividend bit pattern, in either mode and for either signedness.
- R9: With `signed_i`=1, dividing the most negative value by -1 sets `overflow_o`. The quotient is then the most negative value and the remainder is zero. No other operation sets `overflow_o`, and a nonzero divisor never sets `div_zero_o`.
- R10: After reset, `in_ready_o` is high and `out_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operation request |
| in_ready_o | output | 1 | Divider idle; request accepted at the next edge |
| dividend_i | input | WIDTH | Dividend |
| divisor_i | input | WIDTH | Divisor |
| signed_i | input | 1 | 1: two's complement operands; 0: unsigned |
| floor_i | input | 1 | 1: flooring rounding; 0: truncating rounding |
| out_valid_o | output | 1 | Result available |
| out_ready_i | input | 1 | Consumer takes the result |
| quotient_o | output | WIDTH | Quotient |
| remainder_o | output | WIDTH | Remainder |
| div_zero_o | output | 1 | Divisor was zero |
| overflow_o | output | 1 | Signed most-negative / -1 |

## Verification
Two things can fall in the same cycle at the output.

First, a result can become valid while the consumer is stalling it. The bench holds `out_ready_i` low for a chosen number of cycles before the result arrives. On every one of those cycles it checks that the result is still present and unchanged. It also checks that `in_ready_o` stays low until the releasing edge.

Second, the flooring correction and the sign correction both act on the same result. Operand pairs with mixed signs and a nonzero remainder are run in both rounding modes against a behavioural integer model. The two results must differ by exactly the correction step.

Special cases run through the same timed sequence as ordinary division, and their flags and values are judged in the result cycle:
- a zero divisor combined with a negative dividend;
- the most negative value divided by -1.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PREP,
    ST_CALC,
    ST_FIX,
    ST_DONE
  } div_state_e;
endpackage

// File: rtl/div_operand_abs.sv
module div_operand_abs #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] val_i,
  input  logic             signed_i,
  output logic [WIDTH-1:0] mag_o,
  output logic             neg_o
);
  assign neg_o = signed_i & val_i[WIDTH-1];
  // most negative value maps to 2^(WIDTH-1), which fits unsigned
  assign mag_o = neg_o ? (~val_i + 1'b1) : val_i;
endmodule

// File: rtl/div_restore_step.sv
module div_restore_step #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] rem_i,
  input  logic [WIDTH-1:0] quo_i,
  input  logic [WIDTH-1:0] den_i,
  output logic [WIDTH-1:0] rem_o,
  output logic [WIDTH-1:0] quo_o
);
  logic [WIDTH:0]   rem_sh;
  logic [WIDTH+1:0] trial;
  logic             fits;

  assign rem_sh = {rem_i, quo_i[WIDTH-1]};
  assign trial  = {1'b0, rem_sh} - {2'b00, den_i};
  assign fits   = ~trial[WIDTH+1];
  assign rem_o  = fits ? trial[WIDTH-1:0] : rem_sh[WIDTH-1:0];
  assign quo_o  = {quo_i[WIDTH-2:0], fits};
endmodule

// File: rtl/div_result_fix.sv
module div_result_fix #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] qmag_i,
  input  logic [WIDTH-1:0] rmag_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             a_neg_i,
  input  logic             b_neg_i,
  input  logic             signed_i,
  input  logic             floor_i,
  output logic [WIDTH-1:0] quo_o,
  output logic [WIDTH-1:0] rem_o,
  output logic             dz_o,
  output logic             ov_o
);
  localparam logic [WIDTH-1:0] MinVal = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] q_trunc, r_trunc;
  logic             mixed, adjust;

  assign mixed   = a_neg_i ^ b_neg_i;
  assign q_trunc = mixed   ? (~qmag_i + 1'b1) : qmag_i;
  assign r_trunc = a_neg_i ? (~rmag_i + 1'b1) : rmag_i;
  assign adjust  = floor_i & mixed & (rmag_i != '0);
  assign dz_o    = (b_i == '0);
  assign ov_o    = signed_i & (a_i == MinVal) & (b_i == '1);

  always_comb begin
    if (dz_o) begin
      quo_o = '1;
      rem_o = a_i;
    end else if (ov_o) begin
      quo_o = MinVal;
      rem_o = '0;
    end else if (adjust) begin
      quo_o = q_trunc - 1'b1;
      rem_o = r_trunc + b_i;
    end else begin
      quo_o = q_trunc;
      rem_o = r_trunc;
    end
  end
endmodule

// File: rtl/int_divider.sv
module int_divider
  import div_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [WIDTH-1:0] dividend_i,
  input  logic [WIDTH-1:0] divisor_i,
  input  logic             signed_i,
  input  logic             floor_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [WIDTH-1:0] quotient_o,
  output logic [WIDTH-1:0] remainder_o,
  output logic             div_zero_o,
  output logic             overflow_o
);
  localparam int CntW = $clog2(WIDTH + 1);
  localparam logic [CntW-1:0] LastStep = CntW'(WIDTH - 1);

  div_state_e       state_q;
  logic [CntW-1:0]  step_q;
  logic [WIDTH-1:0] a_q, b_q, rem_q, quo_q, den_q;
  logic             sgn_q, flr_q;

  logic [WIDTH-1:0] a_mag, b_mag, rem_nx, quo_nx, fq, fr;
  logic             a_neg, b_neg, fdz, fov;

  div_operand_abs #(.WIDTH(WIDTH)) u_abs_a (
    .val_i(a_q), .signed_i(sgn_q), .mag_o(a_mag), .neg_o(a_neg)
  );
  div_operand_abs #(.WIDTH(WIDTH)) u_abs_b (
    .val_i(b_q), .signed_i(sgn_q), .mag_o(b_mag), .neg_o(b_neg)
  );

  div_restore_step #(.WIDTH(WIDTH)) u_step (
    .rem_i(rem_q), .quo_i(quo_q), .den_i(den_q),
    .rem_o(rem_nx), .quo_o(quo_nx)
  );

  div_result_fix #(.WIDTH(WIDTH)) u_fix (
    .qmag_i(quo_q), .rmag_i(rem_q), .a_i(a_q), .b_i(b_q),
    .a_neg_i(a_neg), .b_neg_i(b_neg), .signed_i(sgn_q), .floor_i(flr_q),
    .quo_o(fq), .rem_o(fr), .dz_o(fdz), .ov_o(fov)
  );

  assign in_ready_o  = (state_q == ST_IDLE);
  assign out_valid_o = (state_q == ST_DONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      step_q      <= '0;
      a_q         <= '0;
      b_q         <= '0;
      sgn_q       <= 1'b0;
      flr_q       <= 1'b0;
      rem_q       <= '0;
      quo_q       <= '0;
      den_q       <= '0;
      quotient_o  <= '0;
      remainder_o <= '0;
      div_zero_o  <= 1'b0;
      overflow_o  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (in_valid_i) begin
          a_q     <= dividend_i;
          b_q     <= divisor_i;
          sgn_q   <= signed_i;
          flr_q   <= floor_i;
          state_q <= ST_PREP;
        end
        ST_PREP: begin
          quo_q   <= a_mag;
          den_q   <= b_mag;
          rem_q   <= '0;
          step_q  <= '0;
          state_q <= ST_CALC;
        end
        ST_CALC: begin
          rem_q  <= rem_nx;
          quo_q  <= quo_nx;
          step_q <= step_q + 1'b1;
          if (step_q == LastStep) state_q <= ST_FIX;
        end
        ST_FIX: begin
          quotient_o  <= fq;
          remainder_o <= fr;
          div_zero_o  <= fdz;
          overflow_o  <= fov;
          state_q     <= ST_DONE;
        end
        ST_DONE: if (out_ready_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/int_divider_chk.sv
module int_divider_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic             in_ready_o,
  input logic [WIDTH-1:0] dividend_i,
  input logic [WIDTH-1:0] divisor_i,
  input logic             signed_i,
  input logic             out_valid_o,
  input logic             out_ready_i,
  input logic [WIDTH-1:0] quotient_o,
  input logic [WIDTH-1:0] remainder_o,
  input logic             div_zero_o,
  input logic             overflow_o
);
  localparam int Lat  = WIDTH + 2;
  localparam int LatW = $clog2(Lat + 1) + 1;
  localparam logic [WIDTH-1:0] MinVal = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] cap_a, cap_b, recon;
  logic             cap_s, busy;
  logic [LatW-1:0]  lat_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_a <= '0; cap_b <= '0; cap_s <= 1'b0; busy <= 1'b0; lat_cnt <= '0;
    end else if (in_valid_i && in_ready_o) begin
      cap_a <= dividend_i; cap_b <= divisor_i; cap_s <= signed_i;
      busy <= 1'b1; lat_cnt <= '0;
    end else if (out_valid_o && out_ready_i) begin
      busy <= 1'b0;
    end else if (busy && lat_cnt != '1) begin
      lat_cnt <= lat_cnt + 1'b1;
    end
  end

  assign recon = quotient_o * cap_b + remainder_o;

  p_excl_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |-> !out_valid_o);
  p_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> busy && lat_cnt == LatW'(Lat));
  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(quotient_o) && $stable(remainder_o));
  p_identity_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !div_zero_o |-> recon == cap_a);
  p_div_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && div_zero_o |-> cap_b == '0 && quotient_o == '1 && remainder_o == cap_a);
  p_overflow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && overflow_o |-> cap_s && cap_a == MinVal && cap_b == '1
                                  && quotient_o == MinVal && remainder_o == '0);
endmodule

bind int_divider int_divider_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
  .dividend_i(dividend_i), .divisor_i(divisor_i), .signed_i(signed_i),
  .out_valid_o(out_valid_o), .out_ready_i(out_ready_i), .quotient_o(quotient_o),
  .remainder_o(remainder_o), .div_zero_o(div_zero_o), .overflow_o(overflow_o)
);

// File: tb/int_divider_tb.sv
`timescale 1ns/1ps
module int_divider_tb;
  localparam int W   = 8;
  localparam int LAT = W + 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0, in_ready;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic         s_in = 1'b0, f_in = 1'b0;
  logic         out_valid, out_ready = 1'b0;
  logic [W-1:0] q_out, r_out;
  logic         dz_out, ov_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  int_divider #(.WIDTH(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .dividend_i(a_in), .divisor_i(b_in), .signed_i(s_in), .floor_i(f_in),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .quotient_o(q_out),
    .remainder_o(r_out), .div_zero_o(dz_out), .overflow_o(ov_out)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic longint sx(input logic [W-1:0] v, input bit s);
    longint t = longint'(v);
    if (s && v[W-1]) t = t - (longint'(1) << W);
    return t;
  endfunction

  // behavioural reference
  task automatic model(input logic [W-1:0] a, input logic [W-1:0] b, input bit s, input bit f,
                       output logic [W-1:0] q, output logic [W-1:0] r,
                       output bit dz, output bit ov);
    longint sa = sx(a, s), sb = sx(b, s), qq, rr;
    dz = 0; ov = 0;
    if (b == '0) begin
      dz = 1; q = '1; r = a;
    end else if (s && sa == -(longint'(1) << (W-1)) && sb == -1) begin
      ov = 1; q = {1'b1, {(W-1){1'b0}}}; r = '0;
    end else begin
      qq = sa / sb;
      rr = sa % sb;
      if (f && rr != 0 && ((sa < 0) != (sb < 0))) begin
        qq = qq - 1; rr = rr + sb;
      end
      q = W'(qq); r = W'(rr);
    end
  endtask

  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input bit s, input bit f,
                        input int hold, input string tag_in);
    logic [W-1:0] eq, er;
    bit edz, eov;
    string tag;
    longint rs;
    tag = tag_in;
    if (tag == "") tag = !s ? "R7" : (f ? "R5" : "R4");
    model(a, b, s, f, eq, er, edz, eov);
    @(negedge clk);
    chk(in_ready == 1'b1, "R1", "in_ready idle", longint'(in_ready), 1);
    in_valid = 1'b1; a_in = a; b_in = b; s_in = s; f_in = f;
    out_ready = (hold == 0);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    a_in = W'($urandom); b_in = W'($urandom); s_in = ~s; f_in = ~f; // R1: inputs change mid-op
    chk(in_ready == 1'b0, "R1", "in_ready busy", longint'(in_ready), 0);
    for (int j = 1; j <= LAT; j++) begin
      @(posedge clk); @(negedge clk);
      chk(out_valid == (j == LAT), "R2", $sformatf("out_valid at edge %0d", j),
          longint'(out_valid), longint'(j == LAT));
    end
    chk(q_out == eq, tag, "quotient", sx(q_out, s), sx(eq, s));
    chk(r_out == er, tag, "remainder", sx(r_out, s), sx(er, s));
    chk(dz_out == edz, edz ? "R8" : "R9", "div_zero flag", longint'(dz_out), longint'(edz));
    chk(ov_out == eov, "R9", "overflow flag", longint'(ov_out), longint'(eov));
    if (s && !edz && !eov) begin
      rs = sx(r_out, 1);
      if (f) chk(rs == 0 || ((rs < 0) == (sx(b, 1) < 0)), "R5", "remainder sign", rs, sx(b, 1));
      else   chk(rs == 0 || ((rs < 0) == (sx(a, 1) < 0)), "R4", "remainder sign", rs, sx(a, 1));
    end
    for (int h = 0; h < hold; h++) begin
      @(posedge clk); @(negedge clk);
      chk(out_valid && q_out == eq && r_out == er, "R3", "held result",
          longint'(q_out), longint'(eq));
      chk(in_ready == 1'b0, "R3", "in_ready during hold", longint'(in_ready), 0);
    end
    out_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R3", "release", longint'(out_valid), 0);
    out_ready = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R10", "reset state",
        longint'({in_ready, out_valid}), 2);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R10", "after reset release",
        longint'({in_ready, out_valid}), 2);

    // R6 reference cases, both modes
    for (int f = 0; f < 2; f++) begin
      run_op(8'd10,  8'd3,  1, f[0], 0, "R6");
      run_op(8'hF6,  8'hFD, 1, f[0], 0, "R6");
      run_op(8'hF6,  8'd3,  1, f[0], 0, "R6");
      run_op(8'd10,  8'hFD, 1, f[0], 0, "R6");
    end
    // R8 / R9 corners
    for (int s = 0; s < 2; s++)
      for (int f = 0; f < 2; f++) begin
        run_op(8'hF6, 8'h00, s[0], f[0], 0, "R8");
        run_op(8'h00, 8'h00, s[0], f[0], 0, "R8");
      end
    run_op(8'h80, 8'hFF, 1, 0, 0, "R9");
    run_op(8'h80, 8'hFF, 1, 1, 2, "R9");
    run_op(8'h80, 8'hFF, 0, 0, 0, "R7");
    run_op(8'h80, 8'h01, 1, 1, 0, "");
    run_op(8'h7F, 8'h80, 1, 1, 0, "R5");
    run_op(8'h7F, 8'h80, 1, 0, 0, "R4");
    run_op(8'hFF, 8'hFF, 0, 1, 0, "R7");
    run_op(8'hFF, 8'h01, 0, 1, 0, "R7");
    // R3 stalls
    run_op(8'hE7, 8'd5, 1, 1, 4, "R3");
    run_op(8'd200, 8'd7, 0, 0, 3, "R3");
    // R7: unsigned, mode bit must not matter
    for (int k = 0; k < 20; k++) begin
      logic [W-1:0] ra = W'($urandom), rb = W'($urandom);
      run_op(ra, rb, 0, 0, 0, "R7");
      run_op(ra, rb, 0, 1, 0, "R7");
    end
    // random signed in both modes
    for (int k = 0; k < 150; k++) begin
      logic [W-1:0] ra = W'($urandom), rb = W'($urandom);
      if (k % 10 == 0) rb = 8'hFF;
      run_op(ra, rb, 1, 0, k % 7 == 0 ? 1 : 0, "");
      run_op(ra, rb, 1, 1, 0, "");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule